// File: doc/BRIEF.md
# Poisoned Packet Handling Unit

This unit sits on the receive and transmit sides of an endpoint's transaction layer. It decides what happens to a received packet whose header marks its data as corrupted. Such packets are not dropped. Ordinary packets still go to the application, and the unit raises a one-cycle advisory-error pulse. It also sets a sticky status bit that software clears by writing a 1 to it.

A configuration write whose data is marked corrupted is treated differently: its write enable towards the configuration space is withheld. Every other configuration write passes its write enable through unchanged.

On the transmit side, every completion produced by the configuration-space logic passes through a scrubber. The scrubber forces the poison bit of the header to zero, so the configuration space can never emit a poisoned packet. All outputs are registered and appear one clock after their cause.

Top module: `poison_handler`

## Requirements
- R1: While reset is held and in the first cycle after it, app_fwd_valid, cfg_wr_en, adv_err_pulse, poison_status and tx_valid_o are all 0.
- R2: A received packet (rx_valid=1) of kind 2'b00 (memory) or 2'b01 (message/other) is forwarded: app_fwd_valid is 1 on the next cycle, whatever the value of rx_poison. Kinds 2'b10 (config read) and 2'b11 (config write) are never forwarded.
- R3: adv_err_pulse is 1 on the cycle after each valid packet with rx_poison=1, of any kind. It is 0 on every other cycle, so a single poisoned packet gives a pulse exactly one cycle wide.
- R4: A valid config write (kind 2'b11) with rx_poison=1 leaves cfg_wr_en at 0 on the next cycle, even when rx_cfg_we=1.
- R5: A valid config write with rx_poison=0 drives cfg_wr_en equal to rx_cfg_we on the next cycle. For every other kind, cfg_wr_en is 0.
- R6: A valid poisoned packet sets poison_status from the next cycle on. The bit stays 1 until it is cleared.
- R7: A software write (sw_wr=1) with sw_wdata bit CLR_BIT (default 3) equal to 1 clears poison_status on the next cycle. A write with that bit equal to 0 has no effect, whatever the other bits hold.
- R8: If a poisoned packet and a clearing write arrive in the same cycle, poison_status is 1 afterwards.
- R9: For each tx_valid_i, the next cycle shows tx_valid_o=1 and tx_hdr_o equal to tx_hdr_i with bit EP_BIT (default 14) forced to 0. All other header bits are unchanged.
- R10: When rx_valid=0, rx_poison and rx_cfg_we have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | Received header fields are valid this cycle |
| rx_kind | input | 2 | Packet class: 00 memory, 01 message/other, 10 config read, 11 config write |
| rx_poison | input | 1 | Poison bit of the received header |
| rx_cfg_we | input | 1 | Write enable requested by a config write |
| sw_wr | input | 1 | Software write strobe to the status register |
| sw_wdata | input | SW_W | Software write data; bit CLR_BIT is write-1-to-clear |
| tx_valid_i | input | 1 | Config-space completion header valid |
| tx_hdr_i | input | HDR_W | Config-space completion header |
| app_fwd_valid | output | 1 | Packet forwarded to the application |
| cfg_wr_en | output | 1 | Write enable to the configuration space |
| adv_err_pulse | output | 1 | Advisory-error pulse |
| poison_status | output | 1 | Sticky poisoned-data status bit |
| tx_valid_o | output | 1 | Scrubbed header valid |
| tx_hdr_o | output | HDR_W | Header with poison bit forced to 0 |

## Verification
Every result of this block is due exactly one rising edge after its cause: forwarding, write enable, advisory pulse, status update and the scrubbed header. The bench therefore drives inputs on a falling edge and samples the outputs on the next falling edge, which lies half a period after the single register stage. Status checks that span several cycles, such as stickiness and the clear-versus-set race, sample after each edge in turn. The pulse-width check samples one more falling edge later, after the inputs have returned to idle.

// File: rtl/poison_pkg.sv
package poison_pkg;
  typedef enum logic [1:0] {
    KIND_MEM    = 2'b00,
    KIND_OTHER  = 2'b01,
    KIND_CFG_RD = 2'b10,
    KIND_CFG_WR = 2'b11
  } pkt_kind_e;

  function automatic logic kind_is_cfg(input logic [1:0] k);
    return (k == KIND_CFG_RD) || (k == KIND_CFG_WR);
  endfunction
endpackage

// File: rtl/poison_rx_path.sv
module poison_rx_path
  import poison_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic [1:0] rx_kind,
  input  logic       rx_poison,
  input  logic       rx_cfg_we,
  output logic       fwd_o,
  output logic       cfg_we_o,
  output logic       adv_o,
  output logic       hit_o
);
  logic is_cfg_wr;
  logic fwd_d;
  logic we_d;

  always_comb begin
    hit_o     = rx_valid & rx_poison;
    is_cfg_wr = rx_valid & (rx_kind == KIND_CFG_WR);
    fwd_d     = rx_valid & ~kind_is_cfg(rx_kind);
    we_d      = is_cfg_wr & rx_cfg_we & ~rx_poison;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_o    <= 1'b0;
      cfg_we_o <= 1'b0;
      adv_o    <= 1'b0;
    end else begin
      fwd_o    <= fwd_d;
      cfg_we_o <= we_d;
      adv_o    <= hit_o;
    end
  end
endmodule

// File: rtl/poison_status_reg.sv
module poison_status_reg #(
  parameter int SW_W    = 8,
  parameter int CLR_BIT = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_i,
  input  logic            sw_wr_i,
  input  logic [SW_W-1:0] sw_wdata_i,
  output logic            status_o
);
  logic clr;

  always_comb clr = sw_wr_i & sw_wdata_i[CLR_BIT];

  always_ff @(posedge clk) begin
    if (rst)        status_o <= 1'b0;
    else if (set_i) status_o <= 1'b1;
    else if (clr)   status_o <= 1'b0;
  end
endmodule

// File: rtl/poison_tx_scrub.sv
module poison_tx_scrub #(
  parameter int HDR_W  = 32,
  parameter int EP_BIT = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic [HDR_W-1:0] hdr_i,
  output logic             valid_o,
  output logic [HDR_W-1:0] hdr_o
);
  logic [HDR_W-1:0] scrubbed;

  for (genvar b = 0; b < HDR_W; b++) begin : g_bit
    if (b == EP_BIT) begin : g_ep
      assign scrubbed[b] = 1'b0;
    end else begin : g_pass
      assign scrubbed[b] = hdr_i[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      hdr_o   <= '0;
    end else begin
      valid_o <= valid_i;
      hdr_o   <= valid_i ? scrubbed : hdr_o;
    end
  end
endmodule

// File: rtl/poison_handler.sv
module poison_handler #(
  parameter int HDR_W   = 32,
  parameter int EP_BIT  = 14,
  parameter int SW_W    = 8,
  parameter int CLR_BIT = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_valid,
  input  logic [1:0]       rx_kind,
  input  logic             rx_poison,
  input  logic             rx_cfg_we,
  input  logic             sw_wr,
  input  logic [SW_W-1:0]  sw_wdata,
  input  logic             tx_valid_i,
  input  logic [HDR_W-1:0] tx_hdr_i,
  output logic             app_fwd_valid,
  output logic             cfg_wr_en,
  output logic             adv_err_pulse,
  output logic             poison_status,
  output logic             tx_valid_o,
  output logic [HDR_W-1:0] tx_hdr_o
);
  logic poison_hit;

  poison_rx_path u_rx (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .rx_kind   (rx_kind),
    .rx_poison (rx_poison),
    .rx_cfg_we (rx_cfg_we),
    .fwd_o     (app_fwd_valid),
    .cfg_we_o  (cfg_wr_en),
    .adv_o     (adv_err_pulse),
    .hit_o     (poison_hit)
  );

  poison_status_reg #(.SW_W(SW_W), .CLR_BIT(CLR_BIT)) u_stat (
    .clk        (clk),
    .rst        (rst),
    .set_i      (poison_hit),
    .sw_wr_i    (sw_wr),
    .sw_wdata_i (sw_wdata),
    .status_o   (poison_status)
  );

  poison_tx_scrub #(.HDR_W(HDR_W), .EP_BIT(EP_BIT)) u_tx (
    .clk     (clk),
    .rst     (rst),
    .valid_i (tx_valid_i),
    .hdr_i   (tx_hdr_i),
    .valid_o (tx_valid_o),
    .hdr_o   (tx_hdr_o)
  );
endmodule

// File: rtl/poison_handler_chk.sv
module poison_handler_chk #(
  parameter int HDR_W   = 32,
  parameter int EP_BIT  = 14,
  parameter int SW_W    = 8,
  parameter int CLR_BIT = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             rx_valid,
  input logic [1:0]       rx_kind,
  input logic             rx_poison,
  input logic             rx_cfg_we,
  input logic             sw_wr,
  input logic [SW_W-1:0]  sw_wdata,
  input logic             tx_valid_i,
  input logic [HDR_W-1:0] tx_hdr_i,
  input logic             app_fwd_valid,
  input logic             cfg_wr_en,
  input logic             adv_err_pulse,
  input logic             poison_status,
  input logic             tx_valid_o,
  input logic [HDR_W-1:0] tx_hdr_o
);
  AST_FWD_NONCFG: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && !rx_kind[1]) |=> app_fwd_valid); // R2
  AST_ADV_NEEDS_POISON: assert property (@(posedge clk) disable iff (rst)
    adv_err_pulse |-> $past(rx_valid && rx_poison)); // R3
  AST_CFG_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_kind == 2'b11 && rx_poison) |=> !cfg_wr_en); // R4
  AST_STATUS_SET: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_poison) |=> poison_status); // R6
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
    (poison_status && !(sw_wr && sw_wdata[CLR_BIT])) |=> poison_status); // R7
  AST_TX_EP_ZERO: assert property (@(posedge clk) disable iff (rst)
    tx_valid_o |-> !tx_hdr_o[EP_BIT]); // R9
endmodule

bind poison_handler poison_handler_chk #(
  .HDR_W(HDR_W), .EP_BIT(EP_BIT), .SW_W(SW_W), .CLR_BIT(CLR_BIT)
) chk_i (.*);

// File: tb/poison_handler_tb.sv
module poison_handler_tb_top;
  localparam int HDR_W = 32;
  localparam int SW_W  = 8;
  localparam int NVEC  = 10;
  // {valid, kind[1:0], poison, we, exp_fwd, exp_cfg, exp_adv}
  localparam logic [7:0] VEC [NVEC] = '{
    8'b1_00_0_0_100, 8'b1_00_1_0_101, 8'b1_01_1_1_101, 8'b1_11_0_1_010,
    8'b1_11_1_1_001, 8'b1_11_0_0_000, 8'b1_10_1_0_001, 8'b0_00_1_1_000,
    8'b1_10_0_1_000, 8'b1_01_0_0_100
  };

  logic clk = 0, rst = 1;
  logic rx_valid = 0, rx_poison = 0, rx_cfg_we = 0, sw_wr = 0, tx_valid_i = 0;
  logic [1:0] rx_kind = 0;
  logic [SW_W-1:0] sw_wdata = 0;
  logic [HDR_W-1:0] tx_hdr_i = 0;
  logic app_fwd_valid, cfg_wr_en, adv_err_pulse, poison_status, tx_valid_o;
  logic [HDR_W-1:0] tx_hdr_o;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  poison_handler dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rx_valid = 0; rx_poison = 0; rx_cfg_we = 0; rx_kind = 0;
    sw_wr = 0; sw_wdata = 0; tx_valid_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fwd", app_fwd_valid, 0);
    check("R1 cfg", cfg_wr_en, 0);
    check("R1 adv", adv_err_pulse, 0);
    check("R1 status", poison_status, 0);
    check("R1 tx", tx_valid_o, 0);
    rst = 0;
    @(negedge clk);
    check("R1 after", {app_fwd_valid, cfg_wr_en, adv_err_pulse, poison_status, tx_valid_o}, 0);

    // table walk: R2 R3 R4 R5 R10
    for (int i = 0; i < NVEC; i++) begin
      {rx_valid, rx_kind, rx_poison, rx_cfg_we} = VEC[i][7:3];
      @(negedge clk);
      check($sformatf("R2 fwd vec%0d", i), app_fwd_valid, VEC[i][2]);
      check($sformatf("R5/R4 cfg vec%0d", i), cfg_wr_en, VEC[i][1]);
      check($sformatf("R3 adv vec%0d", i), adv_err_pulse, VEC[i][0]);
    end
    idle();
    @(negedge clk);
    check("R3 pulse width", adv_err_pulse, 0);

    // R7 clear
    sw_wr = 1; sw_wdata = 8'h08;
    @(negedge clk); idle();
    check("R7 clear", poison_status, 0);
    // R10 invalid poisoned ignored
    rx_poison = 1; rx_cfg_we = 1; rx_kind = 2'b11;
    @(negedge clk); idle();
    check("R10 status", poison_status, 0);
    check("R10 adv", adv_err_pulse, 0);
    check("R10 cfg", cfg_wr_en, 0);
    // R6 set and sticky
    rx_valid = 1; rx_poison = 1;
    @(negedge clk); idle();
    check("R6 set", poison_status, 1);
    repeat (3) @(negedge clk);
    check("R6 sticky", poison_status, 1);
    // R7 write with clear bit 0
    sw_wr = 1; sw_wdata = 8'hF7;
    @(negedge clk); idle();
    check("R7 zero write", poison_status, 1);
    // R8 set wins
    sw_wr = 1; sw_wdata = 8'h08; rx_valid = 1; rx_poison = 1;
    @(negedge clk); idle();
    check("R8 set wins", poison_status, 1);
    sw_wr = 1; sw_wdata = 8'h08;
    @(negedge clk); idle();
    check("R7 clear again", poison_status, 0);

    // R9 transmit scrub
    tx_valid_i = 1; tx_hdr_i = 32'hFFFF_FFFF;
    @(negedge clk);
    check("R9 valid", tx_valid_o, 1);
    check("R9 all ones", tx_hdr_o, 32'hFFFF_BFFF);
    tx_hdr_i = 32'h0000_4000;
    @(negedge clk);
    check("R9 ep only", tx_hdr_o, 32'h0000_0000);
    tx_hdr_i = 32'h1234_5678;
    @(negedge clk); idle();
    check("R9 mixed", tx_hdr_o, 32'h1234_1678);
    @(negedge clk);
    check("R9 valid drop", tx_valid_o, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule